// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block holds eight peripheral interrupt request flags for a small microcontroller. Six peripherals report events as single-cycle pulses: parallel port access, ADC conversion done, synchronous serial transfer done, capture/compare, timer2 period match and timer1 overflow. The block latches each pulse into a sticky flag that only firmware can clear. Two more flags follow the status levels of the UART buffers directly: receive buffer full and transmit buffer empty. Firmware cannot write these two.

No enable gates a flag. Enable masking and priority are left to a later stage that reads `flags_o`. The processor reaches the register over a simple strobe bus. A write loads the writable flags from the write data, and a hardware event that arrives in the same cycle overrides a clear. A read strobe captures the register into a registered read data output. Capture/compare events are dropped while that unit runs in PWM mode.

Top module: `pirq_flags`

## Requirements
- R1: After reset every flag and the read data output are 0.
- R2: Bit positions, MSB to LSB, are: 7 parallel port, 6 ADC done, 5 UART receive full, 4 UART transmit empty, 3 serial done, 2 capture/compare, 1 timer2 match, 0 timer1 overflow.
- R3: An event pulse on a sticky source sets its flag at the next clock edge, with no enable condition.
- R4: A sticky flag stays set through idle cycles and clears only when a write carries 0 in its bit.
- R5: Bit 5 equals the receive-full level and ignores register writes.
- R6: Bit 4 equals the transmit-empty level and ignores register writes.
- R7: A capture/compare event while the PWM mode input is 1 leaves bit 2 unchanged.
- R8: When an event and a write of 0 reach the same sticky bit in one cycle, the bit ends up set.
- R9: A write of 1 to a sticky bit sets it (software-raised request), and a set bit written with 1 stays set.
- R10: `rdata_o` takes the flag value present at the edge where `rd_en_i` is 1, so it shows the value one cycle after the strobe, and it holds when `rd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pport_i | input | 1 | Parallel port access pulse |
| evt_adc_i | input | 1 | ADC conversion done pulse |
| rx_full_i | input | 1 | UART receive buffer full level |
| tx_empty_i | input | 1 | UART transmit buffer empty level |
| evt_ssp_i | input | 1 | Synchronous serial transfer done pulse |
| evt_ccp_i | input | 1 | Capture or compare match pulse |
| ccp_pwm_i | input | 1 | Capture/compare unit is in PWM mode |
| evt_t2match_i | input | 1 | Timer2 equals period pulse |
| evt_t1ovf_i | input | 1 | Timer1 overflow pulse |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rdata_o | output | 8 | Registered read data |
| flags_o | output | 8 | Live flag vector |

## Verification
The bench aims at the same-cycle collision of an event with a clearing write. A design that lets the write win loses that interrupt and reads back 0. It writes all ones and all zeros while the UART levels are held at a known state. A design that stores those bits shows the written value in place of the level. Capture pulses are sent in PWM mode, where a missing gate raises bit 2. Read strobes are compared against a queue of expected snapshots. An off-by-one read path or one that keeps tracking the flags shows a value from the wrong cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int FLAG_W = 8;

  // Bit positions (R2)
  localparam int B_PPORT = 7;
  localparam int B_ADC   = 6;
  localparam int B_RX    = 5;
  localparam int B_TX    = 4;
  localparam int B_SSP   = 3;
  localparam int B_CCP   = 2;
  localparam int B_T2    = 1;
  localparam int B_T1    = 0;

  localparam logic [FLAG_W-1:0] RO_MASK = (FLAG_W'(1) << B_RX) | (FLAG_W'(1) << B_TX);

  // Next state of a sticky flag: hardware set dominates, otherwise a write loads it
  function automatic logic sticky_next(logic cur, logic hw_set, logic we, logic wd);
    return hw_set | (we ? wd : cur);
  endfunction
endpackage

// File: rtl/pirq_event_map.sv
module pirq_event_map
  import pirq_pkg::*;
(
  input  logic              evt_pport_i,
  input  logic              evt_adc_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic              evt_ssp_i,
  input  logic              evt_ccp_i,
  input  logic              ccp_pwm_i,
  input  logic              evt_t2match_i,
  input  logic              evt_t1ovf_i,
  output logic [FLAG_W-1:0] hw_in
);
  always_comb begin
    hw_in          = '0;
    hw_in[B_PPORT] = evt_pport_i;
    hw_in[B_ADC]   = evt_adc_i;
    hw_in[B_RX]    = rx_full_i;
    hw_in[B_TX]    = tx_empty_i;
    hw_in[B_SSP]   = evt_ssp_i;
    hw_in[B_CCP]   = evt_ccp_i & ~ccp_pwm_i;
    hw_in[B_T2]    = evt_t2match_i;
    hw_in[B_T1]    = evt_t1ovf_i;
  end
endmodule

// File: rtl/pirq_sticky_bit.sv
module pirq_sticky_bit
  import pirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic we,
  input  logic wd,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_next(q, hw_set, we, wd);
  end
endmodule

// File: rtl/pirq_rdport.sv
module pirq_rdport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en_i,
  input  logic [W-1:0] din,
  output logic [W-1:0] rdata_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= din;
  end
endmodule

// File: rtl/pirq_flags.sv
module pirq_flags
  import pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_pport_i,
  input  logic              evt_adc_i,
  input  logic              rx_full_i,
  input  logic              tx_empty_i,
  input  logic              evt_ssp_i,
  input  logic              evt_ccp_i,
  input  logic              ccp_pwm_i,
  input  logic              evt_t2match_i,
  input  logic              evt_t1ovf_i,
  input  logic              wr_en_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [FLAG_W-1:0] rdata_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] hw_in;
  logic [FLAG_W-1:0] flag_q;

  pirq_event_map u_map (
    .evt_pport_i   (evt_pport_i),
    .evt_adc_i     (evt_adc_i),
    .rx_full_i     (rx_full_i),
    .tx_empty_i    (tx_empty_i),
    .evt_ssp_i     (evt_ssp_i),
    .evt_ccp_i     (evt_ccp_i),
    .ccp_pwm_i     (ccp_pwm_i),
    .evt_t2match_i (evt_t2match_i),
    .evt_t1ovf_i   (evt_t1ovf_i),
    .hw_in         (hw_in)
  );

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (RO_MASK[i]) begin : g_ro
      // UART status bits are plain levels; write data is dropped (R5, R6)
      logic unused_wd;
      assign unused_wd = wdata_i[i];
      assign flag_q[i] = hw_in[i];
    end else begin : g_st
      pirq_sticky_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_in[i]),
        .we     (wr_en_i),
        .wd     (wdata_i[i]),
        .q      (flag_q[i])
      );
    end
  end

  assign flags_o = flag_q;

  pirq_rdport #(.W(FLAG_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_en_i),
    .din     (flag_q),
    .rdata_o (rdata_o)
  );
endmodule

module pirq_flags_chk
  import pirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [FLAG_W-1:0] wdata_i,
  input logic              rd_en_i,
  input logic              ccp_pwm_i,
  input logic [FLAG_W-1:0] hw_in,
  input logic [FLAG_W-1:0] flags_o,
  input logic [FLAG_W-1:0] rdata_o
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
    if (!RO_MASK[i]) begin : g_st
      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (flags_o[i] && !wr_en_i) |=> flags_o[i]); // R4
      AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && !wdata_i[i] && !hw_in[i]) |=> !flags_o[i]); // R4
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) hw_in[i] |=> flags_o[i]); // R8
      AST_WR_SET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && wdata_i[i]) |=> flags_o[i]); // R9
    end else begin : g_ro
      logic unused_hw;
      assign unused_hw = hw_in[i];
    end
  end

  AST_PWM_MASK: assert property (@(posedge clk) disable iff (!rst_n) (ccp_pwm_i && !flags_o[B_CCP] && !(wr_en_i && wdata_i[B_CCP])) |=> !flags_o[B_CCP]); // R7
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) rd_en_i |=> (rdata_o == $past(flags_o))); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_en_i |=> $stable(rdata_o)); // R10
endmodule

bind pirq_flags pirq_flags_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .rd_en_i   (rd_en_i),
  .ccp_pwm_i (ccp_pwm_i),
  .hw_in     (hw_in),
  .flags_o   (flags_o),
  .rdata_o   (rdata_o)
);

// File: tb/pirq_flags_bench.sv
`timescale 1ns/1ps
module pirq_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;       // bench event vector, indexed by R2 bit positions
  logic       rx_lvl = 1'b0;
  logic       tx_lvl = 1'b0;
  logic       pwm = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata, flags;

  int checks = 0;
  int fails = 0;
  logic [7:0] m = '0;          // model of sticky bits
  logic [7:0] rd_q[$];
  string      rd_req[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;       // 200 MHz

  pirq_flags u_pirq_flags (
    .clk(clk), .rst_n(rst_n),
    .evt_pport_i(evt[7]), .evt_adc_i(evt[6]),
    .rx_full_i(rx_lvl), .tx_empty_i(tx_lvl),
    .evt_ssp_i(evt[3]), .evt_ccp_i(evt[2]), .ccp_pwm_i(pwm),
    .evt_t2match_i(evt[1]), .evt_t1ovf_i(evt[0]),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rdata), .flags_o(flags)
  );

  function automatic logic [7:0] expv();
    return {m[7:6], rx_lvl, tx_lvl, m[3:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Driver: one clock cycle of stimulus, called at a falling edge
  task automatic step(input logic [7:0] ev, input logic we, input logic [7:0] wd,
                      input logic rd, input string req);
    evt = ev; wr_en = we; wdata = wd; rd_en = rd;
    if (rd) begin rd_q.push_back(expv()); rd_req.push_back(req); end
    @(posedge clk);
    for (int b = 0; b < 8; b++) begin
      if (b != 4 && b != 5) begin
        logic s;
        s = ev[b] && !(b == 2 && pwm);
        m[b] = s | (we ? wd[b] : m[b]);
      end
    end
    @(negedge clk);
    evt = '0; wr_en = 1'b0; rd_en = 1'b0;
    chk(req, flags, expv());
  endtask

  // Monitor: pops expected read data one cycle after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected read actual=%02h expected=none", rdata);
      end else begin
        logic [7:0] e;
        string r;
        e = rd_q.pop_front();
        r = rd_req.pop_front();
        chk({r, " R10 read"}, rdata, e);
      end
    end
  end

  initial begin : wd_proc
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk("R1 flags reset", flags, 8'h00);
    chk("R1 rdata reset", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", flags, 8'h00);

    // R2/R3: each sticky source lands on its own bit, then clears by writing 0
    foreach (m[b]) begin
      if (b != 4 && b != 5) begin
        step(8'h01 << b, 1'b0, 8'h00, 1'b0, "R2 R3 event sets bit");
        step(8'h00, 1'b0, 8'h00, 1'b1, "R4 idle hold");
        step(8'h00, 1'b1, 8'h00, 1'b0, "R4 write 0 clears");
      end
    end

    // R4: several flags held through idle, selective clear
    step(8'hCF, 1'b0, 8'h00, 1'b0, "R3 all events");
    repeat (3) step(8'h00, 1'b0, 8'h00, 1'b0, "R4 held");
    step(8'h00, 1'b1, 8'h8A, 1'b1, "R4 partial clear");

    // R5/R6: UART levels, writes ignored
    rx_lvl = 1'b1;
    step(8'h00, 1'b1, 8'h00, 1'b1, "R5 rx level with write 0");
    tx_lvl = 1'b1; rx_lvl = 1'b0;
    step(8'h00, 1'b1, 8'h00, 1'b1, "R6 tx level with write 0");
    tx_lvl = 1'b0;
    step(8'h00, 1'b1, 8'hFF, 1'b1, "R5 R6 write 1 ignored");
    step(8'h00, 1'b1, 8'h00, 1'b0, "R4 clear all");

    // R7: PWM mode drops capture/compare
    pwm = 1'b1;
    step(8'h04, 1'b0, 8'h00, 1'b1, "R7 ccp in pwm");
    step(8'h05, 1'b0, 8'h00, 1'b0, "R7 t1 still sets in pwm");
    pwm = 1'b0;
    step(8'h04, 1'b0, 8'h00, 1'b0, "R7 ccp outside pwm");

    // R8: event beats clearing write
    step(8'h81, 1'b1, 8'h00, 1'b1, "R8 set wins");
    step(8'h00, 1'b0, 8'h00, 1'b1, "R8 readback");

    // R9: software raise
    step(8'h00, 1'b1, 8'h00, 1'b0, "R9 prep clear");
    step(8'h00, 1'b1, 8'h48, 1'b0, "R9 write 1 sets");
    step(8'h00, 1'b1, 8'hCF, 1'b1, "R9 write 1 keeps and sets");

    // R10: read data holds while flags change without a strobe
    step(8'h00, 1'b1, 8'h00, 1'b1, "R10 snapshot");
    @(negedge clk);
    held = rdata;
    step(8'hC3, 1'b0, 8'h00, 1'b0, "R10 flags move");
    chk("R10 hold without strobe", rdata, held);

    repeat (2) @(negedge clk);
    chk("R10 queue drained", 8'(rd_q.size()), 8'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule